// File: doc/BRIEF.md
# LCD Controller Command Sequencer

This block brings up and manages a 128x64 monochrome graphic LCD controller over a write-only serial link. The link has four lines: a serial clock, a serial data line, an active-low chip select and a command/data select. The block only sends commands, so the command/data select stays low for the whole time it runs. Pixel transfer, panel read-back and reset-pin control are handled elsewhere.

A request is made over a valid/ready handshake that carries a 2-bit request kind and an 8-bit argument. The request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a request that is presented while a script runs is back-pressured and has no effect. A requester that keeps `req_valid` high is served as soon as the running script ends. The four request kinds are:

- power-up (kind 0), which runs the full initialisation script;
- contrast (kind 1), which uses the argument;
- sleep entry (kind 2);
- sleep exit (kind 3).

`busy` is high while a script runs. `done` pulses for one cycle when the script has released chip select. The block has its own byte shifter and a millisecond delay counter. The serial half-period and the millisecond length are parameters.

Top module: `lcd_cmd_seq`

## Requirements
- R1: Each byte is sent most significant bit first as eight clock pulses. The serial clock idles low. Data changes only while the clock is low, and the clock is high only while chip select is asserted.
- R2: `lcd_dc` is low whenever `lcd_csn` is low.
- R3: A power-up request first drives chip select low, then raises it, then lowers it again before the first clock pulse. This gives two falling edges of `lcd_csn` per power-up. Every other request gives exactly one falling edge.
- R4: The power-up bytes are, in order: A2, A0, C8, 40, 2C, 2E, 2F, 10, A6, 81, 1E, AF, A5, A4 (hex).
- R5: During power-up there is a pause of at least 100 ms between AF and A5, and at least 200 ms between A5 and A4. Sleep exit pauses at least 50 ms after its last byte, before chip select is released.
- R6: A contrast request (kind 1) with argument v sends 81 and then v shifted right by two bits.
- R7: A sleep-entry request (kind 2) sends AC, 00, AE, A5 and then releases chip select.
- R8: A sleep-exit request (kind 3) sends A4 and then AF, and releases chip select after its pause.
- R9: `req_ready` equals not `busy`. A request presented while busy sends nothing and does not alter the running script. A request presented in the cycle that `done` is high is accepted.
- R10: After reset, `lcd_csn` is high, `lcd_sck` and `lcd_sdo` are low, `busy` and `done` are low, and `req_ready` is high. `busy` rises in the cycle after acceptance. `done` is a one-cycle pulse, and `lcd_csn` is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_kind | input | 2 | 0 power-up, 1 contrast, 2 sleep entry, 3 sleep exit |
| req_arg | input | 8 | Contrast value (ignored by other kinds) |
| busy | output | 1 | Script running |
| done | output | 1 | One-cycle pulse at script end |
| lcd_sck | output | 1 | Serial clock |
| lcd_sdo | output | 1 | Serial data |
| lcd_csn | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | Command/data select, low for command |

## Verification
The end of one script and the acceptance of the next request can fall in the same cycle. `done` and `req_ready` are both high in the cycle after chip select is released. The bench provokes this by holding `req_valid` high from the start of a sleep-entry request and switching the kind to sleep exit while the first script is still running. The test passes when `req_ready` is seen high in the `done` cycle, `busy` rises in the next cycle, and the decoded serial stream holds the four sleep-entry bytes followed by the two sleep-exit bytes, with nothing from the requests that were presented while busy.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {OP_BYTE, OP_WAIT, OP_CS, OP_END} op_e;
  typedef enum logic [1:0] {REQ_INIT, REQ_CONTRAST, REQ_SLEEP, REQ_WAKE} req_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] val;
  } step_t;

  function automatic step_t mk(input op_e o, input logic [7:0] v);
    step_t s;
    s.op  = o;
    s.val = v;
    return s;
  endfunction

  // Script decode: one step per index, OP_END closes every script.
  function automatic step_t script_step(input req_e k, input logic [4:0] i,
                                        input logic [7:0] arg);
    step_t s;
    s = mk(OP_END, 8'h00);
    unique case (k)
      REQ_INIT: begin
        case (i)
          5'd0:  s = mk(OP_CS,   8'h00);
          5'd1:  s = mk(OP_CS,   8'h01);
          5'd2:  s = mk(OP_CS,   8'h00);
          5'd3:  s = mk(OP_BYTE, 8'hA2);
          5'd4:  s = mk(OP_BYTE, 8'hA0);
          5'd5:  s = mk(OP_BYTE, 8'hC8);
          5'd6:  s = mk(OP_BYTE, 8'h40);
          5'd7:  s = mk(OP_BYTE, 8'h2C);
          5'd8:  s = mk(OP_BYTE, 8'h2E);
          5'd9:  s = mk(OP_BYTE, 8'h2F);
          5'd10: s = mk(OP_BYTE, 8'h10);
          5'd11: s = mk(OP_BYTE, 8'hA6);
          5'd12: s = mk(OP_BYTE, 8'h81);
          5'd13: s = mk(OP_BYTE, 8'h1E);
          5'd14: s = mk(OP_BYTE, 8'hAF);
          5'd15: s = mk(OP_WAIT, 8'd100);
          5'd16: s = mk(OP_BYTE, 8'hA5);
          5'd17: s = mk(OP_WAIT, 8'd200);
          5'd18: s = mk(OP_BYTE, 8'hA4);
          default: s = mk(OP_END, 8'h00);
        endcase
      end
      REQ_CONTRAST: begin
        case (i)
          5'd0:  s = mk(OP_CS,   8'h00);
          5'd1:  s = mk(OP_BYTE, 8'h81);
          5'd2:  s = mk(OP_BYTE, arg >> 2);
          default: s = mk(OP_END, 8'h00);
        endcase
      end
      REQ_SLEEP: begin
        case (i)
          5'd0:  s = mk(OP_CS,   8'h00);
          5'd1:  s = mk(OP_BYTE, 8'hAC);
          5'd2:  s = mk(OP_BYTE, 8'h00);
          5'd3:  s = mk(OP_BYTE, 8'hAE);
          5'd4:  s = mk(OP_BYTE, 8'hA5);
          default: s = mk(OP_END, 8'h00);
        endcase
      end
      REQ_WAKE: begin
        case (i)
          5'd0:  s = mk(OP_CS,   8'h00);
          5'd1:  s = mk(OP_BYTE, 8'hA4);
          5'd2:  s = mk(OP_BYTE, 8'hAF);
          5'd3:  s = mk(OP_WAIT, 8'd50);
          default: s = mk(OP_END, 8'h00);
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_byte_shifter.sv
module lcd_byte_shifter #(
  parameter int HALF_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       clr,
  input  logic [7:0] din,
  output logic       sck,
  output logic       sdo,
  output logic       done
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          act;

  assign sdo = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '0;
      bitn <= '0;
      act  <= 1'b0;
      sck  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) sh <= '0;
      if (start && !act) begin
        act  <= 1'b1;
        sh   <= din;
        sck  <= 1'b0;
        cnt  <= '0;
        bitn <= '0;
      end else if (act) begin
        if (cnt == CW'(HALF_CYC - 1)) begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int MS_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] ms,
  output logic       done
);
  localparam int CW = $clog2(MS_CYC + 1);

  logic [CW-1:0] tick;
  logic [7:0]    left;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        left <= ms;
        tick <= '0;
      end else if (run) begin
        if (left == 8'd0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else if (tick == CW'(MS_CYC - 1)) begin
          tick <= '0;
          left <= left - 8'd1;
        end else begin
          tick <= tick + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SCK_HZ   = 1_000_000,
  parameter int HALF_CYC = CLK_HZ / (2 * SCK_HZ),
  parameter int MS_CYC   = CLK_HZ / 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_arg,
  output logic       busy,
  output logic       done,
  output logic       lcd_sck,
  output logic       lcd_sdo,
  output logic       lcd_csn,
  output logic       lcd_dc
);
  localparam int HW = $clog2(HALF_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SHIFT, S_WAIT, S_HOLD} st_e;

  st_e        st;
  req_e       kind_q;
  logic [7:0] arg_q;
  logic [4:0] idx;
  logic [HW-1:0] hold;
  logic       ser_start, ser_clr, ser_done;
  logic       tm_start, tm_done;
  logic [7:0] out_byte;
  logic [7:0] wait_ms;
  step_t      cur;

  assign cur       = script_step(kind_q, idx, arg_q);
  assign busy      = (st != S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign lcd_dc    = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind_q    <= REQ_INIT;
      arg_q     <= '0;
      idx       <= '0;
      hold      <= '0;
      ser_start <= 1'b0;
      ser_clr   <= 1'b0;
      tm_start  <= 1'b0;
      out_byte  <= '0;
      wait_ms   <= '0;
      lcd_csn   <= 1'b1;
      done      <= 1'b0;
    end else begin
      ser_start <= 1'b0;
      ser_clr   <= 1'b0;
      tm_start  <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= req_e'(req_kind);
          arg_q  <= req_arg;
          idx    <= '0;
          st     <= S_STEP;
        end
        S_STEP: begin
          unique case (cur.op)
            OP_BYTE: begin
              out_byte  <= cur.val;
              ser_start <= 1'b1;
              st        <= S_SHIFT;
            end
            OP_WAIT: begin
              wait_ms  <= cur.val;
              tm_start <= 1'b1;
              st       <= S_WAIT;
            end
            OP_CS: begin
              lcd_csn <= (cur.val != 8'h00);
              ser_clr <= 1'b1;
              hold    <= '0;
              st      <= S_HOLD;
            end
            OP_END: begin
              lcd_csn <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end
          endcase
        end
        S_SHIFT: if (ser_done) begin
          idx <= idx + 5'd1;
          st  <= S_STEP;
        end
        S_WAIT: if (tm_done) begin
          idx <= idx + 5'd1;
          st  <= S_STEP;
        end
        S_HOLD: begin
          if (hold == HW'(HALF_CYC - 1)) begin
            idx <= idx + 5'd1;
            st  <= S_STEP;
          end else begin
            hold <= hold + HW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  lcd_byte_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(ser_start), .clr(ser_clr),
    .din(out_byte), .sck(lcd_sck), .sdo(lcd_sdo), .done(ser_done)
  );

  lcd_ms_timer #(.MS_CYC(MS_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tm_start), .ms(wait_ms), .done(tm_done)
  );
endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic lcd_sck,
  input logic lcd_sdo,
  input logic lcd_csn,
  input logic lcd_dc
);
  assert_sck_in_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sck |-> !lcd_csn);
  assert_data_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sck |-> $stable(lcd_sdo));
  assert_cmd_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_csn |-> !lcd_dc);
  assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcd_csn && !busy));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lcd_cmd_seq lcd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo),
  .lcd_csn(lcd_csn), .lcd_dc(lcd_dc)
);

// File: tb/sim_lcd_cmd_seq.sv
module sim_lcd_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int MS   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_arg = 8'd0;
  logic req_ready, busy, done, lcd_sck, lcd_sdo, lcd_csn, lcd_dc;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] cap[$];
  logic [7:0] shreg = 8'd0;
  int nb = 0;
  int cs_falls = 0;
  int dc_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_seq #(.HALF_CYC(HALF), .MS_CYC(MS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_arg(req_arg), .busy(busy), .done(done),
    .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo), .lcd_csn(lcd_csn), .lcd_dc(lcd_dc)
  );

  // Serial decoder: MSB-first capture on each rising clock
  always @(posedge lcd_sck) begin
    shreg = {shreg[6:0], lcd_sdo};
    nb = nb + 1;
    if (lcd_dc !== 1'b0) dc_bad = dc_bad + 1;
    if (nb == 8) begin
      cap.push_back(shreg);
      nb = 0;
    end
  end

  always @(negedge lcd_csn) if (rst_n) cs_falls = cs_falls + 1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] k);
    case (k)
      2'd0: return 14;
      2'd1: return 2;
      2'd2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] k, input int i, input logic [7:0] a);
    logic [7:0] pw [14] = '{8'hA2, 8'hA0, 8'hC8, 8'h40, 8'h2C, 8'h2E, 8'h2F,
                            8'h10, 8'hA6, 8'h81, 8'h1E, 8'hAF, 8'hA5, 8'hA4};
    logic [7:0] sl [4] = '{8'hAC, 8'h00, 8'hAE, 8'hA5};
    case (k)
      2'd0: return pw[i];
      2'd1: return (i == 0) ? 8'h81 : {2'b00, a[7:2]};
      2'd2: return sl[i];
      default: return (i == 0) ? 8'hA4 : 8'hAF;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'd0: return "R4";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_req(input logic [1:0] k, input logic [7:0] a, input bit poke);
    int cyc;
    cap.delete(); nb = 0; cs_falls = 0; dc_bad = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = k; req_arg = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    cyc = 1;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_kind = 2'd2; req_valid = 1'b1;
      repeat (4) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
      cyc += 7;
    end
    while (!done) begin @(negedge clk); cyc++; end
    chk(lcd_csn == 1'b1, "R10 csn at done", lcd_csn, 1);
    chk(cap.size() == exp_len(k), {tag(k), " byte count"}, cap.size(), exp_len(k));
    for (int i = 0; i < cap.size() && i < exp_len(k); i++)
      chk(cap[i] == exp_byte(k, i, a), {tag(k), " byte"}, cap[i], exp_byte(k, i, a));
    chk(cs_falls == ((k == 2'd0) ? 2 : 1), "R3 select edges", cs_falls, (k == 2'd0) ? 2 : 1);
    chk(dc_bad == 0, "R2 dc low", dc_bad, 0);
    chk(nb == 0, "R1 whole bytes", nb, 0);
    if (k == 2'd0) chk(cyc >= 300 * MS, "R5 power-up pauses", cyc, 300 * MS);
    if (k == 2'd3) chk(cyc >= 50 * MS, "R5 wake pause", cyc, 50 * MS);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(lcd_csn == 1'b1 && lcd_sck == 1'b0 && lcd_sdo == 1'b0, "R10 reset lines",
        {lcd_csn, lcd_sck, lcd_sdo}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R10 reset status",
        {busy, done, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    run_req(2'd0, 8'h00, 1'b0);          // R4 power-up
    run_req(2'd1, 8'h00, 1'b0);          // R6 corner: zero
    run_req(2'd1, 8'hFF, 1'b0);          // R6 corner: full scale
    run_req(2'd1, 8'h03, 1'b0);          // R6 corner: drops to zero
    run_req(2'd1, 8'h5A, 1'b1);          // R9 requests while busy
    run_req(2'd2, 8'h00, 1'b0);          // R7
    run_req(2'd3, 8'h00, 1'b0);          // R8
    for (int n = 0; n < 10; n++)
      run_req(2'($urandom_range(1, 3)), 8'($urandom_range(0, 255)), 1'b0);

    // R9: back-to-back acceptance in the done cycle
    cap.delete(); nb = 0;
    @(negedge clk);
    req_kind = 2'd2; req_valid = 1'b1;
    @(negedge clk);
    req_kind = 2'd3;
    while (!done) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready in done cycle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 second request taken", busy, 1);
    while (!done) @(negedge clk);
    chk(cap.size() == 6, "R9 chained byte count", cap.size(), 6);
    for (int i = 0; i < cap.size() && i < 6; i++) begin
      logic [7:0] e;
      e = (i < 4) ? exp_byte(2'd2, i, 8'h00) : exp_byte(2'd3, i - 4, 8'h00);
      chk(cap[i] == e, "R9 chained byte", cap[i], e);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule